// File: doc/BRIEF.md
# Posted Request Ordering Tracker

This block sits in user logic next to a PCIe transmit core and keeps a completion from overtaking posted requests sent before it. Each posted write the user logic sends carries an 8-bit sequence number, handed out in strictly increasing modular order. When the number is issued, the block marks that number as outstanding in a one-bit-per-number table. The core later announces, on either of two report ports, which posted requests have reached its internal ordering point. Up to two reports can arrive in one cycle, and each one clears its table bit.

Completions enter through a valid/ready gate. On acceptance the gate records the most recently issued posted number as the completion's dependency mark. The completion is held until no outstanding entry lies at or before that mark, where "before" is measured modulo 256 back from the newest issued number. It is then presented downstream. While a completion is inside the gate, the upstream ready stays low.

The gate is a three-state machine:
- GATE_IDLE: accepting. On upstream valid, the machine goes to GATE_HOLD.
- GATE_HOLD: waiting on the dependency. When nothing at or before the mark is outstanding, it goes to GATE_SEND.
- GATE_SEND: presenting the completion. On downstream ready, it goes back to GATE_IDLE.

Top module: `posted_order_tracker`

## Requirements
- R1: An accepted issue (`post_valid` and `post_ready` high at a clock edge) marks `post_seq` outstanding. `post_ready` is low exactly while 255 numbers are outstanding.
- R2: A pulse on report port 0 (`ack0_valid` with `ack0_seq`) clears that number's outstanding mark.
- R3: A pulse on report port 1 alone clears that number's outstanding mark.
- R4: Two reports for different numbers in the same cycle clear both marks in that cycle.
- R5: When a number is issued and reported in the same cycle, the report wins and the number ends up not outstanding.
- R6: A report for a number that is not outstanding sets `ack_err`. `ack_err` stays high until reset, and the table is left unchanged.
- R7: In GATE_IDLE, `cpl_in_ready` is 1. A completion accepted there records the newest issued number as its mark. `cpl_in_ready` stays 0 until the completion has left downstream.
- R8: A held completion waits while any outstanding number lies at or before its mark. Numbers issued after acceptance do not hold it.
- R9: A report that clears the last blocking number moves the gate to GATE_SEND at the same edge. `cpl_out_valid` is high in the following cycle.
- R10: While `cpl_out_valid` is high and `cpl_out_ready` is low, `cpl_out_valid` and `cpl_out_data` hold steady.
- R11: A completion accepted when no posted number has ever been issued since reset spends one cycle in GATE_HOLD, then goes to GATE_SEND.
- R12: The ordering is wrap-safe. A mark of 0 taken after numbers 254 and 255 still waits on 254 and 255.
- R13: Synchronous active-high `rst` clears the table and `ack_err` and puts the gate in GATE_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | A posted request is being issued |
| post_seq | input | 8 | Sequence number of the issued posted request |
| post_ready | output | 1 | Low when the table is full (255 outstanding) |
| ack0_valid | input | 1 | Report port 0 pulse |
| ack0_seq | input | 8 | Number reported on port 0 |
| ack1_valid | input | 1 | Report port 1 pulse |
| ack1_seq | input | 8 | Number reported on port 1 |
| cpl_in_valid | input | 1 | Upstream completion valid |
| cpl_in_data | input | DATA_W | Upstream completion payload/handle |
| cpl_in_ready | output | 1 | Gate can accept a completion |
| cpl_out_valid | output | 1 | Released completion valid |
| cpl_out_data | output | DATA_W | Released completion payload/handle |
| cpl_out_ready | input | 1 | Downstream accepts the completion |
| ack_err | output | 1 | Sticky flag: a report named a number that was not outstanding |

## Verification
The dependency match is exercised with reports on port 0 only, on port 1 only, and on both ports in one cycle. This separates a design that watches one port from one that watches both. Other runs put a posted request issued after the completion next to one issued before it, which shows whether the mark bounds the dependency. A same-cycle issue-and-report and a report of a number that was never issued check the report priority and the error path. A sequence that crosses 255 to 0, together with a run that fills the table to 255, checks the modular comparison and the issue stall.

// File: rtl/pot_pkg.sv
package pot_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_HOLD = 2'd1,
        GATE_SEND = 2'd2
    } gate_state_e;
endpackage

// File: rtl/pot_pend_table.sv
module pot_pend_table #(
    parameter int SEQ_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    issue_fire,
    input  logic [SEQ_W-1:0]        issue_seq,
    input  logic                    r0_v,
    input  logic [SEQ_W-1:0]        r0_seq,
    input  logic                    r1_v,
    input  logic [SEQ_W-1:0]        r1_seq,
    output logic [(1<<SEQ_W)-1:0]   live_o,
    output logic [SEQ_W:0]          count_o,
    output logic                    err_o
);
    localparam int DEPTH = 1 << SEQ_W;

    logic [DEPTH-1:0] pend_q, set_m, clr_m;
    logic [SEQ_W:0]   count_q;
    logic             err_q;
    logic             hit0, hit1, bad;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (issue_fire) set_m[issue_seq] = 1'b1;
        if (r0_v)       clr_m[r0_seq]    = 1'b1;
        if (r1_v)       clr_m[r1_seq]    = 1'b1;
    end

    // a report only counts when it finds a mark (existing or arriving now)
    assign hit0 = r0_v && (pend_q[r0_seq] || set_m[r0_seq]);
    assign hit1 = r1_v && (pend_q[r1_seq] || set_m[r1_seq])
                  && !(r0_v && (r0_seq == r1_seq));
    assign bad  = (r0_v && !hit0) || (r1_v && !hit1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            count_q <= '0;
            err_q   <= 1'b0;
        end else begin
            pend_q  <= (pend_q | set_m) & ~clr_m;
            count_q <= count_q + (SEQ_W+1)'(issue_fire)
                               - (SEQ_W+1)'(hit0) - (SEQ_W+1)'(hit1);
            if (bad) err_q <= 1'b1;
        end
    end

    // reports in flight this cycle already count as cleared
    assign live_o  = pend_q & ~clr_m;
    assign count_o = count_q;
    assign err_o   = err_q;

    a_r1_issue_sets: assert property (@(posedge clk) disable iff (rst)
        issue_fire && !(r0_v && r0_seq == issue_seq) && !(r1_v && r1_seq == issue_seq)
        |=> pend_q[$past(issue_seq)]);
    a_r1_count_cap: assert property (@(posedge clk) disable iff (rst)
        count_q <= (SEQ_W+1)'(DEPTH-1));
    a_r2_port0_clears: assert property (@(posedge clk) disable iff (rst)
        r0_v && pend_q[r0_seq] |=> !pend_q[$past(r0_seq)]);
    a_r3_port1_clears: assert property (@(posedge clk) disable iff (rst)
        r1_v && pend_q[r1_seq] |=> !pend_q[$past(r1_seq)]);
    a_r5_report_wins: assert property (@(posedge clk) disable iff (rst)
        issue_fire && r0_v && r0_seq == issue_seq |=> !pend_q[$past(issue_seq)]);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: rtl/pot_dep_check.sv
module pot_dep_check #(
    parameter int SEQ_W = 8
) (
    input  logic [(1<<SEQ_W)-1:0] live_i,
    input  logic [SEQ_W-1:0]      last_i,
    input  logic [SEQ_W-1:0]      mark_i,
    input  logic                  dep_en_i,
    output logic                  blocked_o
);
    localparam int DEPTH = 1 << SEQ_W;

    logic [SEQ_W-1:0] mark_dist;
    logic [DEPTH-1:0] older_hit;

    // distance back from the newest issued number orders entries modulo 2^SEQ_W
    assign mark_dist = last_i - mark_i;

    for (genvar n = 0; n < DEPTH; n++) begin : g_entry
        logic [SEQ_W-1:0] ent_dist;
        assign ent_dist     = last_i - SEQ_W'(n);
        assign older_hit[n] = live_i[n] && (ent_dist >= mark_dist);
    end

    assign blocked_o = dep_en_i && (|older_hit);
endmodule

// File: rtl/pot_release_fsm.sv
module pot_release_fsm
    import pot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              blocked,
    output logic              capture
);
    gate_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          data_q <= '0;
        else if (capture) data_q <= in_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (in_valid)   state_d = GATE_HOLD;
            GATE_HOLD: if (!blocked)   state_d = GATE_SEND;
            GATE_SEND: if (out_ready)  state_d = GATE_IDLE;
            default:                   state_d = GATE_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            GATE_IDLE: in_ready  = 1'b1;
            GATE_HOLD: ;
            GATE_SEND: out_valid = 1'b1;
            default:   ;
        endcase
    end

    assign capture  = in_ready && in_valid;
    assign out_data = data_q;

    a_r7_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_ready, out_valid}));
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/posted_order_tracker.sv
module posted_order_tracker #(
    parameter int SEQ_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_valid,
    input  logic [SEQ_W-1:0]  post_seq,
    output logic              post_ready,
    input  logic              ack0_valid,
    input  logic [SEQ_W-1:0]  ack0_seq,
    input  logic              ack1_valid,
    input  logic [SEQ_W-1:0]  ack1_seq,
    input  logic              cpl_in_valid,
    input  logic [DATA_W-1:0] cpl_in_data,
    output logic              cpl_in_ready,
    output logic              cpl_out_valid,
    output logic [DATA_W-1:0] cpl_out_data,
    input  logic              cpl_out_ready,
    output logic              ack_err
);
    localparam int DEPTH = 1 << SEQ_W;
    localparam logic [SEQ_W:0] FULL = (SEQ_W+1)'(DEPTH-1);

    logic [DEPTH-1:0] live;
    logic [SEQ_W:0]   count;
    logic             issue_fire, blocked, capture;
    logic [SEQ_W-1:0] last_q, mark_q;
    logic             have_q, dep_q;

    assign post_ready = (count != FULL);
    assign issue_fire = post_valid && post_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            have_q <= 1'b0;
            mark_q <= '0;
            dep_q  <= 1'b0;
        end else begin
            if (issue_fire) begin
                last_q <= post_seq;
                have_q <= 1'b1;
            end
            if (capture) begin
                mark_q <= last_q;
                dep_q  <= have_q;
            end
        end
    end

    pot_pend_table #(.SEQ_W(SEQ_W)) u_table (
        .clk(clk), .rst(rst),
        .issue_fire(issue_fire), .issue_seq(post_seq),
        .r0_v(ack0_valid), .r0_seq(ack0_seq),
        .r1_v(ack1_valid), .r1_seq(ack1_seq),
        .live_o(live), .count_o(count), .err_o(ack_err)
    );

    pot_dep_check #(.SEQ_W(SEQ_W)) u_dep (
        .live_i(live), .last_i(last_q), .mark_i(mark_q),
        .dep_en_i(dep_q), .blocked_o(blocked)
    );

    pot_release_fsm #(.DATA_W(DATA_W)) u_gate (
        .clk(clk), .rst(rst),
        .in_valid(cpl_in_valid), .in_data(cpl_in_data), .in_ready(cpl_in_ready),
        .out_valid(cpl_out_valid), .out_data(cpl_out_data), .out_ready(cpl_out_ready),
        .blocked(blocked), .capture(capture)
    );

    a_r8_no_early_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cpl_out_valid) |-> !$past(blocked));
    a_r12_seq_in_order: assert property (@(posedge clk) disable iff (rst)
        issue_fire && have_q |-> post_seq == last_q + SEQ_W'(1));
endmodule

// File: tb/posted_order_tracker_bench.sv
module posted_order_tracker_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        post_valid, ack0_valid, ack1_valid;
    logic [7:0]  post_seq, ack0_seq, ack1_seq;
    logic        post_ready;
    logic        cpl_in_valid, cpl_in_ready, cpl_out_valid, cpl_out_ready, ack_err;
    logic [31:0] cpl_in_data, cpl_out_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] nxt = 8'd0;

    always #4 clk = ~clk;   // 125 MHz

    posted_order_tracker u_posted_order_tracker (
        .clk(clk), .rst(rst),
        .post_valid(post_valid), .post_seq(post_seq), .post_ready(post_ready),
        .ack0_valid(ack0_valid), .ack0_seq(ack0_seq),
        .ack1_valid(ack1_valid), .ack1_seq(ack1_seq),
        .cpl_in_valid(cpl_in_valid), .cpl_in_data(cpl_in_data), .cpl_in_ready(cpl_in_ready),
        .cpl_out_valid(cpl_out_valid), .cpl_out_data(cpl_out_data),
        .cpl_out_ready(cpl_out_ready), .ack_err(ack_err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue_one();
        post_valid = 1'b1; post_seq = nxt;
        tick();
        post_valid = 1'b0;
        nxt = nxt + 8'd1;
    endtask

    task automatic rpt(logic v0, logic [7:0] s0, logic v1, logic [7:0] s1);
        ack0_valid = v0; ack0_seq = s0; ack1_valid = v1; ack1_seq = s1;
        tick();
        ack0_valid = 1'b0; ack1_valid = 1'b0;
    endtask

    task automatic issue_and_report();
        post_valid = 1'b1; post_seq = nxt;
        ack0_valid = 1'b1; ack0_seq = nxt;
        tick();
        post_valid = 1'b0; ack0_valid = 1'b0;
        nxt = nxt + 8'd1;
    endtask

    task automatic push(string tag, logic [31:0] d);
        chk({tag, " in_ready idle"}, 32'(cpl_in_ready), 32'd1);
        cpl_in_valid = 1'b1; cpl_in_data = d;
        tick();
        cpl_in_valid = 1'b0;
        chk({tag, " in_ready low while held"}, 32'(cpl_in_ready), 32'd0);
        chk({tag, " no output during hold"}, 32'(cpl_out_valid), 32'd0);
    endtask

    task automatic expect_out(string tag, logic [31:0] d);
        chk({tag, " out_valid"}, 32'(cpl_out_valid), 32'd1);
        chk({tag, " out_data"}, cpl_out_data, d);
        tick();
        chk({tag, " drained"}, 32'(cpl_out_valid), 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        post_valid = 0; ack0_valid = 0; ack1_valid = 0; cpl_in_valid = 0;
        post_seq = 0; ack0_seq = 0; ack1_seq = 0; cpl_in_data = 0;
        cpl_out_ready = 1'b1;
        tick(); tick();
        rst = 1'b0;
        nxt = 8'd0;
        tick();
    endtask

    task automatic t_reset_state();
        chk("R13 in_ready", 32'(cpl_in_ready), 32'd1);
        chk("R13 out_valid", 32'(cpl_out_valid), 32'd0);
        chk("R13 err", 32'(ack_err), 32'd0);
        chk("R13 post_ready", 32'(post_ready), 32'd1);
    endtask

    task automatic t_no_posted();
        push("R11", 32'h1111);
        tick();
        expect_out("R11", 32'h1111);
    endtask

    task automatic t_port0();
        logic [7:0] a = nxt;
        issue_one();
        push("R2", 32'h2222);
        tick();
        chk("R2 still held", 32'(cpl_out_valid), 32'd0);
        rpt(1'b1, a, 1'b0, 8'd0);
        expect_out("R2 R9", 32'h2222);
    endtask

    task automatic t_port1();
        logic [7:0] a = nxt;
        issue_one();
        push("R3", 32'h3333);
        tick();
        chk("R3 still held", 32'(cpl_out_valid), 32'd0);
        rpt(1'b0, 8'd0, 1'b1, a);
        expect_out("R3", 32'h3333);
    endtask

    task automatic t_both_ports();
        logic [7:0] a = nxt;
        logic [7:0] b;
        issue_one();
        b = nxt;
        issue_one();
        push("R4", 32'h4444);
        rpt(1'b1, b, 1'b0, 8'd0);
        chk("R4 one of two cleared", 32'(cpl_out_valid), 32'd0);
        issue_one();                       // newer posted must not matter
        rpt(1'b1, a, 1'b1, nxt - 8'd1);
        expect_out("R4", 32'h4444);
    endtask

    task automatic t_same_cycle();
        issue_and_report();
        push("R5", 32'h5555);
        tick();
        expect_out("R5", 32'h5555);
        chk("R5 no error", 32'(ack_err), 32'd0);
    endtask

    task automatic t_later_posted();
        logic [7:0] a = nxt;
        logic [7:0] b;
        issue_one();
        push("R8", 32'h8888);
        b = nxt;
        issue_one();
        rpt(1'b1, a, 1'b0, 8'd0);
        expect_out("R8 later posted ignored", 32'h8888);
        rpt(1'b0, 8'd0, 1'b1, b);
    endtask

    task automatic t_backpressure();
        logic [7:0] a = nxt;
        issue_one();
        push("R10", 32'hA0A0);
        cpl_out_ready = 1'b0;
        rpt(1'b1, a, 1'b0, 8'd0);
        for (int i = 0; i < 3; i++) begin
            chk("R10 valid held", 32'(cpl_out_valid), 32'd1);
            chk("R10 data held", cpl_out_data, 32'hA0A0);
            tick();
        end
        cpl_out_ready = 1'b1;
        tick();
        chk("R10 drained", 32'(cpl_out_valid), 32'd0);
    endtask

    task automatic t_stall();
        logic [7:0] base = nxt;
        for (int i = 0; i < 255; i++) issue_one();
        chk("R1 full stalls issue", 32'(post_ready), 32'd0);
        rpt(1'b1, base, 1'b0, 8'd0);
        chk("R1 ready after one report", 32'(post_ready), 32'd1);
        for (int i = 1; i < 255; i += 2)
            rpt(1'b1, base + 8'(i), 1'b1, base + 8'(i + 1));
        chk("R1 all reports valid", 32'(ack_err), 32'd0);
    endtask

    task automatic t_wrap();
        while (nxt != 8'd254) issue_and_report();
        issue_one(); issue_one(); issue_one();   // 254, 255, 0
        push("R12", 32'hC0C0);
        rpt(1'b1, 8'd0, 1'b1, 8'd255);
        chk("R12 254 still blocks", 32'(cpl_out_valid), 32'd0);
        tick();
        chk("R12 still held", 32'(cpl_out_valid), 32'd0);
        rpt(1'b1, 8'd254, 1'b0, 8'd0);
        expect_out("R12", 32'hC0C0);
    endtask

    task automatic t_bad_report();
        logic [7:0] a = nxt;
        issue_one();
        rpt(1'b1, a + 8'd5, 1'b0, 8'd0);
        chk("R6 err set", 32'(ack_err), 32'd1);
        push("R6", 32'h6666);
        tick();
        chk("R6 table unchanged", 32'(cpl_out_valid), 32'd0);
        rpt(1'b0, 8'd0, 1'b1, a);
        expect_out("R6", 32'h6666);
        chk("R6 err sticky", 32'(ack_err), 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_no_posted();
        t_port0();
        t_port1();
        t_both_ports();
        t_same_cycle();
        t_later_posted();
        t_backpressure();
        t_stall();
        t_wrap();
        t_bad_report();
        do_reset();
        t_reset_state();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule